// File: doc/BRIEF.md
# Calendar Timekeeper With Commit Trigger

This block keeps wall-clock time and a calendar date in hardware. One pulse per second on an input advances seconds, minutes, hours, day of week, day of month, month and year. Month lengths and the leap-year rule for February are handled in the counter.

Software uses a 16-bit synchronous register port. It writes a new time into a set of staging registers in any order, at any pace. It then writes the commit register. At that moment every staged field is copied into the running counter on one clock edge, so no partially updated time is ever visible. A busy flag in the status register stays high for a short, fixed window after each accepted commit. Commit writes that arrive inside that window are dropped.

Reads of the time registers always return the running counter, never the staging values. The year is held as a 7-bit count of years since 1968. Months are numbered 1 to 12.

Top module: `rtc_calendar`

## Requirements
- R1: After a synchronous active-low reset the live time reads second 0, minute 0, hour 0, day of month 1, day of week 1, month 1, year 0 (meaning 1968), and the status register reads 0.
- R2: Writes to the time registers at byte addresses 0x0A, 0x0C, 0x0E, 0x10, 0x12, 0x14, 0x16 only change staging storage. The live time read back is unchanged until a commit.
- R3: A write to address 0x3C with data bit 0 set, while not busy, loads all seven staged fields into the live counter on that clock edge. A write there with bit 0 clear has no effect.
- R4: After an accepted commit, bit 6 of the status register at address 0x00 reads 1 for exactly BUSY_CYCLES clock cycles (default 4), then reads 0. All other status bits read 0.
- R5: A commit write made while busy is ignored. The live time keeps the values from the earlier commit.
- R6: Each cycle with sec_tick high advances the seconds. Seconds wrap 59 to 0 with a carry into minutes, minutes wrap 59 to 0 with a carry into hours, and hours wrap 23 to 0 with a carry into the day.
- R7: The day of month wraps to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12. The month then advances.
- R8: February ends after day 29 when the year field is a multiple of 4, and after day 28 otherwise.
- R9: Month 12 wraps to month 1 and increments the year. Year 127 wraps to 0.
- R10: The day of week (encoding 0 to 6) advances by one on every day carry, and 6 wraps to 0.
- R11: When sec_tick and an accepted commit occur in the same cycle, the live time equals the staged values exactly and that tick is lost.
- R12: Time registers read as zero-extended 16-bit values: seconds at 0x0A, minutes at 0x0C, hours at 0x0E, day of month at 0x10, day of week at 0x12, month at 0x14, year at 0x16. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |

## Verification
A wrong carry decision in the cascade shows up on the very next read after the offending tick. A missed month end or leap test leaves an impossible date, such as April 31 or February 29 in a non-leap year, in the day and month registers. A bad busy counter either stretches or cuts the window in the status bit. It also lets a second commit overwrite the live time, which becomes visible on the first read of that field. Dates are placed directly at rollover boundaries by commit, so each carry path is covered by a single tick followed by a read of all seven fields.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [2:0] dow;
        logic [4:0] dom;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_t;

    localparam cal_t CAL_RESET = '{year: 7'd0, mon: 4'd1, dow: 3'd1, dom: 5'd1,
                                   hour: 5'd0, min: 6'd0, sec: 6'd0};

    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 16;
    localparam int BUSY_BIT = 6;

    localparam logic [ADDR_W-1:0] A_STATUS = 6'h00;
    localparam logic [ADDR_W-1:0] A_SEC    = 6'h0A;
    localparam logic [ADDR_W-1:0] A_MIN    = 6'h0C;
    localparam logic [ADDR_W-1:0] A_HOUR   = 6'h0E;
    localparam logic [ADDR_W-1:0] A_DOM    = 6'h10;
    localparam logic [ADDR_W-1:0] A_DOW    = 6'h12;
    localparam logic [ADDR_W-1:0] A_MON    = 6'h14;
    localparam logic [ADDR_W-1:0] A_YEAR   = 6'h16;
    localparam logic [ADDR_W-1:0] A_COMMIT = 6'h3C;

    // Last day of a month; the year counts from a leap year, so year%4==0 is leap.
    function automatic logic [4:0] last_day(input logic [3:0] mon, input logic [6:0] year);
        case (mon)
            4'd2:                      last_day = (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   last_day = 5'd30;
            default:                   last_day = 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_commit_ctl.sv
module rtc_commit_ctl #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_req,
    output logic commit_go,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        busy      = (st_q.cnt != '0);
        commit_go = trig_req && !busy;
        if (commit_go)
            st_d.cnt = CW'(BUSY_CYCLES);
        else if (busy)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  cal_t              live,
    input  logic              busy,
    output cal_t              staged,
    output logic              trig_req,
    output logic [DATA_W-1:0] bus_rdata
);
    cal_t stg_q, stg_d;
    logic unused_wdata_hi;

    assign unused_wdata_hi = &{1'b0, bus_wdata[DATA_W-1:7]};
    assign staged   = stg_q;
    assign trig_req = bus_wr && (bus_addr == A_COMMIT) && bus_wdata[0];

    always_comb begin
        stg_d = stg_q;
        if (bus_wr) begin
            case (bus_addr)
                A_SEC:  stg_d.sec  = bus_wdata[5:0];
                A_MIN:  stg_d.min  = bus_wdata[5:0];
                A_HOUR: stg_d.hour = bus_wdata[4:0];
                A_DOM:  stg_d.dom  = bus_wdata[4:0];
                A_DOW:  stg_d.dow  = bus_wdata[2:0];
                A_MON:  stg_d.mon  = bus_wdata[3:0];
                A_YEAR: stg_d.year = bus_wdata[6:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STATUS: bus_rdata[BUSY_BIT] = busy;
            A_SEC:    bus_rdata = DATA_W'(live.sec);
            A_MIN:    bus_rdata = DATA_W'(live.min);
            A_HOUR:   bus_rdata = DATA_W'(live.hour);
            A_DOM:    bus_rdata = DATA_W'(live.dom);
            A_DOW:    bus_rdata = DATA_W'(live.dow);
            A_MON:    bus_rdata = DATA_W'(live.mon);
            A_YEAR:   bus_rdata = DATA_W'(live.year);
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= CAL_RESET;
        else        stg_q <= stg_d;
    end
endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    input  cal_t load_val,
    output cal_t live
);
    cal_t cal_q, cal_d;

    assign live = cal_q;

    always_comb begin
        cal_d = cal_q;
        if (load) begin
            cal_d = load_val;
        end else if (tick) begin
            cal_d.sec = cal_q.sec + 6'd1;
            if (cal_q.sec >= 6'd59) begin
                cal_d.sec = '0;
                cal_d.min = cal_q.min + 6'd1;
                if (cal_q.min >= 6'd59) begin
                    cal_d.min  = '0;
                    cal_d.hour = cal_q.hour + 5'd1;
                    if (cal_q.hour >= 5'd23) begin
                        cal_d.hour = '0;
                        cal_d.dow  = (cal_q.dow >= 3'd6) ? 3'd0 : cal_q.dow + 3'd1;
                        cal_d.dom  = cal_q.dom + 5'd1;
                        if (cal_q.dom >= last_day(cal_q.mon, cal_q.year)) begin
                            cal_d.dom = 5'd1;
                            cal_d.mon = cal_q.mon + 4'd1;
                            if (cal_q.mon >= 4'd12) begin
                                cal_d.mon  = 4'd1;
                                cal_d.year = cal_q.year + 7'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cal_q <= CAL_RESET;
        else        cal_q <= cal_d;
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    cal_t live;
    cal_t staged;
    logic trig_req;
    logic commit_go;
    logic busy;

    rtc_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .live      (live),
        .busy      (busy),
        .staged    (staged),
        .trig_req  (trig_req),
        .bus_rdata (bus_rdata)
    );

    rtc_commit_ctl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_req  (trig_req),
        .commit_go (commit_go),
        .busy      (busy)
    );

    rtc_cal_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .load     (commit_go),
        .load_val (staged),
        .live     (live)
    );
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic trig_req,
    input logic commit_go,
    input logic busy,
    input cal_t live,
    input cal_t staged
);
    localparam int RW = $clog2(BUSY_CYCLES + 2);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    // R4: busy window never longer than the parameter
    assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RW'(BUSY_CYCLES)));

    // R4: an accepted commit raises busy on the next cycle
    assert_busy_after_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_req && !busy) |=> busy);

    // R3 / R11: an accepted commit loads the staged fields, tick or not
    assert_commit_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |=> (live == $past(staged)));

    // R5: a trigger while busy leaves the live time to the tick path only
    assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_req && busy && !tick) |=> $stable(live));

    // R2: with no tick and no commit the live time holds
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !commit_go) |=> $stable(live));

    // R6: a tick below 59 seconds steps only the seconds
    assert_sec_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !commit_go && live.sec < 6'd59) |=>
            (live.sec == $past(live.sec) + 6'd1 && live.min == $past(live.min)));
endmodule

bind rtc_calendar rtc_calendar_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sec_tick),
    .trig_req  (trig_req),
    .commit_go (commit_go),
    .busy      (busy),
    .live      (live),
    .staged    (staged)
);

// File: tb/rtc_calendar_bench.sv
`timescale 1ns/1ps
module rtc_calendar_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [5:0]  addr;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    rtc_calendar #(.BUSY_CYCLES(4)) u_rtc_calendar (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // monitor: compare read data shortly after the edge that follows the request
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                vectors++;
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%h actual=%h expected=%h",
                             it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic tick1();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic stage(input int s, input int m, input int h, input int dm,
                         input int dw, input int mo, input int y);
        wr(6'h0A, 16'(s)); wr(6'h0C, 16'(m)); wr(6'h0E, 16'(h));
        wr(6'h10, 16'(dm)); wr(6'h12, 16'(dw)); wr(6'h14, 16'(mo));
        wr(6'h16, 16'(y));
    endtask

    task automatic set_time(input int s, input int m, input int h, input int dm,
                            input int dw, input int mo, input int y);
        stage(s, m, h, dm, dw, mo, y);
        wr(6'h3C, 16'h0001);
        idle(6);
    endtask

    task automatic expect_time(input int s, input int m, input int h, input int dm,
                               input int dw, input int mo, input int y, input string tag);
        rd(6'h0A, 16'(s),  {tag, " sec"});
        rd(6'h0C, 16'(m),  {tag, " min"});
        rd(6'h0E, 16'(h),  {tag, " hour"});
        rd(6'h10, 16'(dm), {tag, " dom"});
        rd(6'h12, 16'(dw), {tag, " dow"});
        rd(6'h14, 16'(mo), {tag, " mon"});
        rd(6'h16, 16'(y),  {tag, " year"});
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 / R12: reset state, status clear, unmapped address reads 0
        expect_time(0, 0, 0, 1, 1, 1, 0, "R1 reset");
        rd(6'h00, 16'h0000, "R1 status");
        rd(6'h02, 16'h0000, "R12 unmapped");

        // R2: staging alone changes nothing
        stage(10, 20, 5, 15, 3, 6, 50);
        expect_time(0, 0, 0, 1, 1, 1, 0, "R2 staged only");

        // R3: commit with bit0 clear ignored
        wr(6'h3C, 16'h0002);
        expect_time(0, 0, 0, 1, 1, 1, 0, "R3 bit0 clear");

        // R3 / R4: accepted commit loads, busy visible then clears
        wr(6'h3C, 16'h0001);
        rd(6'h00, 16'h0040, "R4 busy set");
        idle(4);
        rd(6'h00, 16'h0000, "R4 busy clear");
        expect_time(10, 20, 5, 15, 3, 6, 50, "R3 commit");

        // R6: single tick
        tick1();
        expect_time(11, 20, 5, 15, 3, 6, 50, "R6 tick");

        // R6: minute carry
        set_time(59, 5, 0, 10, 2, 3, 1);
        tick1();
        expect_time(0, 6, 0, 10, 2, 3, 1, "R6 min carry");

        // R6 R7 R9 R10: year end, dow 6 wraps to 0
        set_time(59, 59, 23, 31, 6, 12, 31);
        tick1();
        expect_time(0, 0, 0, 1, 0, 1, 32, "R9 year end R10 dow");

        // R8: leap year Feb 28 -> 29, Feb 29 -> Mar 1
        set_time(59, 59, 23, 28, 2, 2, 32);
        tick1();
        expect_time(0, 0, 0, 29, 3, 2, 32, "R8 leap 28");
        set_time(59, 59, 23, 29, 3, 2, 32);
        tick1();
        expect_time(0, 0, 0, 1, 4, 3, 32, "R8 leap 29");

        // R8: non-leap Feb 28 -> Mar 1
        set_time(59, 59, 23, 28, 5, 2, 33);
        tick1();
        expect_time(0, 0, 0, 1, 6, 3, 33, "R8 common 28");

        // R7: 30-day month
        set_time(59, 59, 23, 30, 1, 4, 40);
        tick1();
        expect_time(0, 0, 0, 1, 2, 5, 40, "R7 april end");

        // R7: 31-day month does not wrap at 30
        set_time(59, 59, 23, 30, 1, 7, 40);
        tick1();
        expect_time(0, 0, 0, 31, 2, 7, 40, "R7 july 30");

        // R9: year 127 wraps to 0
        set_time(59, 59, 23, 31, 4, 12, 127);
        tick1();
        expect_time(0, 0, 0, 1, 5, 1, 0, "R9 year wrap");

        // R5: trigger while busy ignored
        stage(1, 2, 3, 4, 5, 6, 7);
        wr(6'h3C, 16'h0001);
        wr(6'h0A, 16'd40);
        wr(6'h3C, 16'h0001);
        idle(6);
        expect_time(1, 2, 3, 4, 5, 6, 7, "R5 busy ignore");
        wr(6'h3C, 16'h0001);
        idle(6);
        expect_time(40, 2, 3, 4, 5, 6, 7, "R5 later commit");

        // R11: tick in the commit cycle is dropped
        stage(30, 8, 9, 12, 0, 11, 60);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'h3C; bus_wdata = 16'h0001; sec_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; sec_tick = 1'b0;
        expect_time(30, 8, 9, 12, 0, 11, 60, "R11 tick drop");

        idle(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule